// File: doc/BRIEF.md
# Configuration Port Index/Data Decoder

This block decodes the configuration space of a legacy multi-function I/O controller. The host reaches it through an 8-bit port that has two consecutive addresses: an index port at the base address and a data port at base+1. After reset the space is locked. Two writes of 0x87 in a row to the index port unlock it, and a write of 0xAA to the index port locks it again. While the space is unlocked, an index write selects a register and data-port accesses read or write that register.

Register 0x07 holds a device number, and this number chooses which per-device register bank the device indices reach. Seven device numbers are implemented. Each device has an enable bit, two 16-bit I/O base addresses and an interrupt number. All of these are driven out continuously so that downstream address decoders can use them. A window of shared registers at 0x20–0x2F reaches the same storage whatever device is selected.

Top module: `sio_cfg_decoder`

## Requirements
- R1: After reset the space is locked, `cfg_open` is 0, every device output (enable, both bases, IRQ) is 0, and a read of either port returns 0xFF.
- R2: Two consecutive index-port writes of 0x87 unlock the space. `cfg_open` goes to 1 after the clock edge that takes the second write.
- R3: While locked, any index-port write other than 0x87 restarts the unlock match. The sequence 0x87, 0x55, 0x87 leaves the space locked, and one more 0x87 then unlocks it.
- R4: While unlocked, an index-port write of 0xAA locks the space. After that, data-port reads return 0xFF and data-port writes change nothing.
- R5: While locked, data-port writes change no register and no output, and reads of the index port or the data port return 0xFF.
- R6: `host_addr` = 0 selects the index port and `host_addr` = 1 selects the data port. While unlocked, a read of the index port returns the last index written (any value except 0xAA).
- R7: Index 0x07 is a read/write device-number register that resets to 0x00. The implemented numbers 0x01, 0x02, 0x04, 0x05, 0x06, 0x07 and 0x0A map to output slots 0 to 6 in that order.
- R8: Device index 0x30 bit 0 is the enable of the selected device. It drives `dev_enable[slot]`, and it reads back as {7'b0, enable}.
- R9: Device indices 0x60 and 0x61 hold the high and low byte of the first I/O base, driven on `dev_base0[slot*16 +: 16]`. Indices 0x62 and 0x63 hold the second base in the same way on `dev_base1`. All four read back.
- R10: Device index 0x70 holds the IRQ number of the selected device, driven on `dev_irq[slot*8 +: 8]`. It reads back.
- R11: Indices 0x20 to 0x2F are sixteen shared 8-bit read/write registers that reset to 0x00. The same storage is reached whatever the device number is.
- R12: With an unimplemented device number selected, device indices read 0x00 and writes to them change no device output.
- R13: While unlocked, indices with no register read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Single-cycle write strobe |
| host_addr | input | 1 | Port select: 0 index, 1 data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the port addressed by `host_addr` (combinational) |
| cfg_open | output | 1 | Configuration space unlocked |
| dev_enable | output | 7 | Enable bit per device slot |
| dev_base0 | output | 112 | First I/O base per slot, 16 bits each |
| dev_base1 | output | 112 | Second I/O base per slot, 16 bits each |
| dev_irq | output | 56 | IRQ number per slot, 8 bits each |

## Verification
The assertions check the following on every cycle: a locked port reads 0xFF, unlocking always follows an index write of 0x87, a 0xAA index write while unlocked always locks, and no device output moves on any cycle without an unlocked data-port write. Other behaviour can only be shown by the bench's scenarios. These include the order of the unlock sequence and its restart, the mapping of device numbers to slots, the placement of the base bytes, the sharing of the global window across device numbers, and the silent handling of unimplemented device numbers and indices.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and types for the configuration-port decoder.
// Assumes an 8-bit host data path and a fixed set of device numbers.
package sio_cfg_pkg;

    localparam int DW       = 8;
    localparam int NUM_DEV  = 7;

    localparam logic [7:0] KEY_UNLOCK = 8'h87;
    localparam logic [7:0] KEY_LOCK   = 8'hAA;

    localparam logic [7:0] IDX_DEVNUM  = 8'h07;
    localparam logic [7:0] IDX_ENABLE  = 8'h30;
    localparam logic [7:0] IDX_B0_HI   = 8'h60;
    localparam logic [7:0] IDX_B0_LO   = 8'h61;
    localparam logic [7:0] IDX_B1_HI   = 8'h62;
    localparam logic [7:0] IDX_B1_LO   = 8'h63;
    localparam logic [7:0] IDX_IRQ     = 8'h70;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_t;

    // Device number served by each output slot, in slot order.
    function automatic logic [7:0] slot_devnum(input int slot);
        case (slot)
            0:       slot_devnum = 8'h01;
            1:       slot_devnum = 8'h02;
            2:       slot_devnum = 8'h04;
            3:       slot_devnum = 8'h05;
            4:       slot_devnum = 8'h06;
            5:       slot_devnum = 8'h07;
            6:       slot_devnum = 8'h0A;
            default: slot_devnum = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/sio_cfg_lock.sv
// Unlock/lock sequencer for the index port.
// Watches index-port writes. Two 0x87 in a row open the space, and 0xAA
// closes it. Reports when an index write should load the index register.
module sio_cfg_lock
    import sio_cfg_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idx_wr,
    input  logic [W-1:0] wdata,
    output logic         open,
    output logic         idx_load
);
    lock_state_t state;

    // Advance the unlock match on every index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_IDLE;
        end else if (idx_wr) begin
            case (state)
                LK_IDLE: state <= (wdata == KEY_UNLOCK) ? LK_HALF : LK_IDLE;
                LK_HALF: state <= (wdata == KEY_UNLOCK) ? LK_OPEN : LK_IDLE;
                LK_OPEN: state <= (wdata == KEY_LOCK)   ? LK_IDLE : LK_OPEN;
                default: state <= LK_IDLE;
            endcase
        end
    end

    // Expose the unlocked flag and the index-load qualifier.
    always_comb begin
        open     = (state == LK_OPEN);
        idx_load = open && idx_wr && (wdata != KEY_LOCK);
    end
endmodule

// File: rtl/sio_glb_regs.sv
// Shared register window reached independently of the device number.
// Assumes BASE+COUNT fits in the index range.
module sio_glb_regs
    import sio_cfg_pkg::*;
#(
    parameter int          W     = DW,
    parameter int          COUNT = 16,
    parameter logic [7:0]  BASE  = 8'h20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [7:0]   idx,
    input  logic [W-1:0] wdata,
    output logic         hit,
    output logic [W-1:0] rdata
);
    localparam int AW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [W-1:0] regs [COUNT];
    logic [7:0]   offs;

    // Decode whether the index falls inside the window.
    always_comb begin
        offs = idx - BASE;
        hit  = (idx >= BASE) && ({1'b0, idx} < ({1'b0, BASE} + 9'(COUNT)));
    end

    // Store data-port writes that hit the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++) regs[i] <= '0;
        end else if (wr_en && hit) begin
            regs[offs[AW-1:0]] <= wdata;
        end
    end

    // Return the addressed register, or zero outside the window.
    always_comb begin
        rdata = hit ? regs[offs[AW-1:0]] : '0;
    end
endmodule

// File: rtl/sio_dev_bank.sv
// Register bank of one logical device: enable, two I/O bases, IRQ.
// Writes arrive only when this bank is the selected one.
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int W = DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     idx,
    input  logic [W-1:0]   wdata,
    output logic           enable,
    output logic [2*W-1:0] base0,
    output logic [2*W-1:0] base1,
    output logic [W-1:0]   irq,
    output logic [W-1:0]   rdata
);
    // Update whichever device register the index names.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            base0  <= '0;
            base1  <= '0;
            irq    <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_ENABLE: enable          <= wdata[0];
                IDX_B0_HI:  base0[2*W-1:W]  <= wdata;
                IDX_B0_LO:  base0[W-1:0]    <= wdata;
                IDX_B1_HI:  base1[2*W-1:W]  <= wdata;
                IDX_B1_LO:  base1[W-1:0]    <= wdata;
                IDX_IRQ:    irq             <= wdata;
                default: ;
            endcase
        end
    end

    // Read back the device register the index names.
    always_comb begin
        case (idx)
            IDX_ENABLE: rdata = {{(W-1){1'b0}}, enable};
            IDX_B0_HI:  rdata = base0[2*W-1:W];
            IDX_B0_LO:  rdata = base0[W-1:0];
            IDX_B1_HI:  rdata = base1[2*W-1:W];
            IDX_B1_LO:  rdata = base1[W-1:0];
            IDX_IRQ:    rdata = irq;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/sio_cfg_decoder.sv
// Index/data configuration decoder. Holds the index and device-number
// registers, routes data-port traffic to the global window or to the
// selected device bank, and drives every device's decoded settings.
// Assumes single-cycle write strobes and a combinational read path.
module sio_cfg_decoder
    import sio_cfg_pkg::*;
#(
    parameter int          N_DEV    = NUM_DEV,
    parameter int          W        = DW,
    parameter int          GLB_CNT  = 16,
    parameter logic [7:0]  GLB_BASE = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_addr,
    input  logic [W-1:0]       host_wdata,
    output logic [W-1:0]       host_rdata,
    output logic               cfg_open,
    output logic [N_DEV-1:0]   dev_enable,
    output logic [N_DEV*2*W-1:0] dev_base0,
    output logic [N_DEV*2*W-1:0] dev_base1,
    output logic [N_DEV*W-1:0] dev_irq
);
    logic           idx_wr, dat_wr, idx_load;
    logic [7:0]     index_q;
    logic [7:0]     devnum_q;
    logic [N_DEV-1:0] sel;
    logic           sel_any;
    logic           glb_hit;
    logic [W-1:0]   glb_rdata;
    logic [W-1:0]   bank_rdata [N_DEV];
    logic [W-1:0]   dev_rdata;

    // Split host writes by port.
    always_comb begin
        idx_wr = host_wr && !host_addr;
        dat_wr = host_wr &&  host_addr && cfg_open;
    end

    sio_cfg_lock #(.W(W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (host_wdata),
        .open     (cfg_open),
        .idx_load (idx_load)
    );

    // Hold the current index and the device number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q  <= 8'h00;
            devnum_q <= 8'h00;
        end else begin
            if (idx_load) index_q <= host_wdata[7:0];
            if (dat_wr && index_q == IDX_DEVNUM) devnum_q <= host_wdata[7:0];
        end
    end

    sio_glb_regs #(.W(W), .COUNT(GLB_CNT), .BASE(GLB_BASE)) u_glb (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dat_wr),
        .idx   (index_q),
        .wdata (host_wdata),
        .hit   (glb_hit),
        .rdata (glb_rdata)
    );

    // One bank per implemented device number.
    for (genvar s = 0; s < N_DEV; s++) begin : g_dev
        assign sel[s] = (devnum_q == slot_devnum(s));

        sio_dev_bank #(.W(W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (dat_wr && sel[s]),
            .idx    (index_q),
            .wdata  (host_wdata),
            .enable (dev_enable[s]),
            .base0  (dev_base0[s*2*W +: 2*W]),
            .base1  (dev_base1[s*2*W +: 2*W]),
            .irq    (dev_irq[s*W +: W]),
            .rdata  (bank_rdata[s])
        );
    end

    // Combine bank read data from the selected device only.
    always_comb begin
        dev_rdata = '0;
        for (int s = 0; s < N_DEV; s++) begin
            if (sel[s]) dev_rdata = dev_rdata | bank_rdata[s];
        end
        sel_any = |sel;
    end

    // Build the port read value.
    always_comb begin
        if (!cfg_open) begin
            host_rdata = '1;
        end else if (!host_addr) begin
            host_rdata = W'(index_q);
        end else if (index_q == IDX_DEVNUM) begin
            host_rdata = W'(devnum_q);
        end else if (glb_hit) begin
            host_rdata = glb_rdata;
        end else if (sel_any) begin
            host_rdata = dev_rdata;
        end else begin
            host_rdata = '0;
        end
    end
endmodule

// File: rtl/sio_cfg_decoder_chk.sv
// Port-level checker for the configuration decoder, bound to every instance.
module sio_cfg_decoder_chk
    import sio_cfg_pkg::*;
#(
    parameter int N_DEV = NUM_DEV,
    parameter int W     = DW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic               host_addr,
    input logic [W-1:0]       host_wdata,
    input logic [W-1:0]       host_rdata,
    input logic               cfg_open,
    input logic [N_DEV-1:0]   dev_enable,
    input logic [N_DEV*2*W-1:0] dev_base0,
    input logic [N_DEV*2*W-1:0] dev_base1,
    input logic [N_DEV*W-1:0] dev_irq
);
    AST_LOCKED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> host_rdata == '1);                                  // R5

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(host_wr && !host_addr && host_wdata == KEY_UNLOCK)); // R2

    AST_LOCK_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open && host_wr && !host_addr && host_wdata == KEY_LOCK |=> !cfg_open); // R4

    AST_ENABLE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr && cfg_open) |=> $stable(dev_enable));     // R8

    AST_BASES_NEED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr && cfg_open) |=> $stable(dev_base0) && $stable(dev_base1)); // R9

    AST_IRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr && cfg_open) |=> $stable(dev_irq));        // R10
endmodule

bind sio_cfg_decoder sio_cfg_decoder_chk #(.N_DEV(N_DEV), .W(W)) u_chk (.*);

// File: tb/sio_cfg_decoder_test.sv
module sio_cfg_decoder_test;
    localparam int ND = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_wr = 1'b0;
    logic           host_addr = 1'b0;
    logic [7:0]     host_wdata = 8'h00;
    logic [7:0]     host_rdata;
    logic           cfg_open;
    logic [ND-1:0]  dev_enable;
    logic [ND*16-1:0] dev_base0, dev_base1;
    logic [ND*8-1:0]  dev_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] devnums [ND] = '{8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h07, 8'h0A};

    sio_cfg_decoder uut (.*);

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        wr(1'b0, i); wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
        wr(1'b0, i); rd(1'b1, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1", "open", cfg_open, 0);
        check("R1", "enables", dev_enable, 0);
        check("R1", "bases", (|dev_base0) | (|dev_base1) | (|dev_irq), 0);
        rd(1'b1, d); check("R1", "data read", d, 8'hFF);
        rd(1'b0, d); check("R1", "index read", d, 8'hFF);
    endtask

    task automatic t_restart();
        wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
        check("R3", "broken sequence stays locked", cfg_open, 0);
        wr(1'b0, 8'h87);
        check("R3", "rematch unlocks", cfg_open, 1);
        wr(1'b0, 8'hAA);
    endtask

    task automatic t_locked_ignore();
        logic [7:0] d;
        wr(1'b1, 8'h01); wr(1'b1, 8'hFF);
        check("R5", "locked write no enable", dev_enable, 0);
        rd(1'b1, d); check("R5", "locked data read", d, 8'hFF);
    endtask

    task automatic t_unlock();
        logic [7:0] d;
        wr(1'b0, 8'h87);
        check("R2", "half key still locked", cfg_open, 0);
        wr(1'b0, 8'h87);
        check("R2", "unlocked", cfg_open, 1);
        wr(1'b0, 8'h5C); rd(1'b0, d);
        check("R6", "index readback", d, 8'h5C);
        rd(1'b1, d); check("R13", "unimplemented index", d, 8'h00);
        wr(1'b1, 8'h33); rd(1'b1, d);
        check("R13", "unimplemented index after write", d, 8'h00);
        reg_rd(8'h07, d); check("R7", "device number reset", d, 8'h00);
    endtask

    task automatic t_devices();
        logic [7:0] d;
        for (int s = 0; s < ND; s++) begin
            reg_wr(8'h07, devnums[s]);
            reg_wr(8'h30, (s % 2 == 0) ? 8'hFF : 8'hFE);
            reg_wr(8'h60, 8'(8'h10 + s));
            reg_wr(8'h61, 8'(8'hA0 + s));
            reg_wr(8'h62, 8'(8'h20 + s));
            reg_wr(8'h63, 8'(8'hB0 + s));
            reg_wr(8'h70, 8'(s + 3));
        end
        for (int s = 0; s < ND; s++) begin
            check("R8", $sformatf("enable slot %0d", s), dev_enable[s], (s % 2 == 0) ? 1 : 0);
            check("R9", $sformatf("base0 slot %0d", s), dev_base0[s*16 +: 16], {8'(8'h10 + s), 8'(8'hA0 + s)});
            check("R9", $sformatf("base1 slot %0d", s), dev_base1[s*16 +: 16], {8'(8'h20 + s), 8'(8'hB0 + s)});
            check("R10", $sformatf("irq slot %0d", s), dev_irq[s*8 +: 8], s + 3);
        end
        reg_wr(8'h07, 8'h05);
        reg_rd(8'h07, d); check("R7", "device number readback", d, 8'h05);
        reg_rd(8'h30, d); check("R8", "enable readback", d, 8'h00);
        reg_rd(8'h61, d); check("R9", "base0 low readback", d, 8'hA3);
        reg_rd(8'h62, d); check("R9", "base1 high readback", d, 8'h23);
        reg_rd(8'h70, d); check("R10", "irq readback", d, 6);
        reg_wr(8'h07, 8'h0A);
        reg_rd(8'h30, d); check("R8", "enable readback slot6", d, 8'h01);
    endtask

    task automatic t_global();
        logic [7:0] d;
        reg_wr(8'h07, 8'h01);
        reg_wr(8'h20, 8'h11);
        reg_wr(8'h2F, 8'hEE);
        reg_wr(8'h07, 8'h0A);
        reg_rd(8'h20, d); check("R11", "global 0x20 shared", d, 8'h11);
        reg_rd(8'h2F, d); check("R11", "global 0x2F shared", d, 8'hEE);
        reg_rd(8'h25, d); check("R11", "global reset value", d, 8'h00);
    endtask

    task automatic t_bad_devnum();
        logic [7:0] d;
        logic [ND-1:0]    en0 = dev_enable;
        logic [ND*8-1:0]  irq0 = dev_irq;
        logic [ND*16-1:0] b0 = dev_base0;
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h30, 8'h01);
        reg_wr(8'h70, 8'h99);
        reg_wr(8'h60, 8'h77);
        check("R12", "enables unchanged", dev_enable, en0);
        check("R12", "irq unchanged", dev_irq == irq0, 1);
        check("R12", "base unchanged", dev_base0 == b0, 1);
        reg_rd(8'h70, d); check("R12", "irq reads zero", d, 8'h00);
        reg_rd(8'h30, d); check("R12", "enable reads zero", d, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        logic [ND*8-1:0] irq0;
        reg_wr(8'h07, 8'h01);
        wr(1'b0, 8'h70);
        wr(1'b0, 8'hAA);
        check("R4", "locked again", cfg_open, 0);
        irq0 = dev_irq;
        wr(1'b1, 8'h42);
        check("R4", "write after lock ignored", dev_irq == irq0, 1);
        rd(1'b1, d); check("R4", "read after lock", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_restart();
        t_locked_ignore();
        t_unlock();
        t_devices();
        t_global();
        t_bad_devnum();
        t_lock();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule